// File: doc/BRIEF.md
# Dual-Rate Watchdog Reset Timer

This block watches for a stalled or runaway program. Every CPU clock tick that reaches it goes through a fixed divide-by-16 prescaler, and the prescaler drives a binary up-counter. If software does not restart the count before the selected counter stage rolls over, the block issues a single-cycle system reset request. Software restarts the count by writing a one to a strobe bit in a shared mode control byte. The same byte holds a rate bit that selects a long period or a short period.

Counting stops while the device is in either of its two low-power states. A static enable input stands for a build-time option. When that input is low, the timer is held at zero and never requests a reset. The oscillator-switching bits that share the control byte are not part of this block. Writes to them are accepted and dropped, and they read back as zero.

Top module: `wdog_reset_timer`

## Requirements
- R1: While reset is asserted, `wdog_rst_o` is 0 and `cfg_rdata_o` reads 8'h00, so the rate defaults to the long period.
- R2: With rate bit 0, a reset pulse follows exactly 16·2^LONG_STAGE counted ticks after the last restart.
- R3: With rate bit 1 (byte bit 5), a reset pulse follows exactly 16·2^SHORT_STAGE counted ticks after the last restart.
- R4: A write with byte bit 6 set zeroes both the prescaler and the counter, so a full period is needed again from that point.
- R5: A write with bit 6 clear does not alter the count or the timing of the next pulse.
- R6: The reset pulse lasts one clock cycle. After it, counting restarts from zero, so the next pulse comes one full period later.
- R7: While `lp_green_i` or `lp_halt_i` is high, ticks are not counted and the count is kept. No pulse is issued in that state.
- R8: While `wdog_en_i` is low, no pulse is issued and the count is held at zero.
- R9: A restart strobe in the same cycle as an overflow wins: no pulse is issued and the count restarts.
- R10: A switch to the short rate takes effect at once. If the count already exceeds the short limit, the pulse follows the next prescaler rollover.
- R11: Reads return the rate in bit 5 and zero in every other bit. The restart strobe always reads 0.
- R12: Only cycles with `tick_i` high advance the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | CPU clock enable; one tick per high cycle |
| wdog_en_i | input | 1 | Static enable (build option) |
| lp_green_i | input | 1 | Slow low-power state active |
| lp_halt_i | input | 1 | Power-down state active |
| cfg_we_i | input | 1 | Write strobe for the control byte |
| cfg_wdata_i | input | 8 | Control byte: bit 6 restart strobe, bit 5 rate select |
| cfg_rdata_o | output | 8 | Control byte readback |
| wdog_rst_o | output | 1 | One-cycle reset request |

## Verification
The reset request is registered. It rises on the clock edge that consumes the final counted tick, and the bench samples it one time unit after that edge. A write to the control byte shows on the readback after the same edge, and the bench checks the readback at that point. A counted-tick reference, updated once per driven cycle, gives the expected pulse for every cycle. This covers clears, rate changes, low-power gaps and the disabled state with no extra bookkeeping. For the first two cycles after reset release, the internal reset synchroniser is still active, so the bench sends no ticks and no writes during that time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W      = 8;
  localparam int CLR_BIT    = 6;
  localparam int RATE_BIT   = 5;
  localparam int PRE_BITS   = 4;

  typedef logic [CFG_W-1:0] cfg_byte_t;

  function automatic cfg_byte_t pack_readback(input logic rate);
    cfg_byte_t b;
    b           = '0;
    b[RATE_BIT] = rate;
    return b;
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  cfg_byte_t wdata_i,
  output logic      rate_o,
  output logic      clr_o,
  output cfg_byte_t rdata_o
);
  logic rate_q, rate_d;

  always_comb begin
    rate_d = rate_q;
    if (we_i) rate_d = wdata_i[RATE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= 1'b0;
    else         rate_q <= rate_d;
  end

  assign clr_o   = we_i & wdata_i[CLR_BIT];
  assign rate_o  = rate_q;
  assign rdata_o = pack_readback(rate_q);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic carry_o
);
  logic [BITS-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (clr_i)      div_d = '0;
    else if (run_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign carry_o = run_i & (&div_q);
endmodule

// File: rtl/wdog_stage_counter.sv
module wdog_stage_counter #(
  parameter int LONG_STAGE  = 14,
  parameter int SHORT_STAGE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  input  logic rate_i,
  output logic ovf_o
);
  localparam int CNT_W = LONG_STAGE;
  localparam logic [CNT_W-1:0] LONG_LAST  = '1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_STAGE) - 64'd1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_val;

  generate
    if (SHORT_STAGE < LONG_STAGE) begin : g_dual
      assign last_val = rate_i ? SHORT_LAST : LONG_LAST;
    end else begin : g_single
      assign last_val = LONG_LAST;
    end
  endgenerate

  assign ovf_o = step_i & (cnt_q >= last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || ovf_o) cnt_d = '0;
    else if (step_i)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_reset_timer.sv
module wdog_reset_timer
  import wdog_pkg::*;
#(
  parameter int LONG_STAGE  = 14,
  parameter int SHORT_STAGE = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wdog_en_i,
  input  logic       lp_green_i,
  input  logic       lp_halt_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  output logic       wdog_rst_o
);
  logic rst_core_n;
  logic rate, clr_strobe, run, pre_clr, pre_carry, ovf;
  logic pulse_q, pulse_d;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_core_n)
  );

  wdog_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .rate_o (rate),
    .clr_o  (clr_strobe),
    .rdata_o(cfg_rdata_o)
  );

  assign run     = tick_i & wdog_en_i & ~lp_green_i & ~lp_halt_i;
  assign pre_clr = clr_strobe | ~wdog_en_i;

  wdog_prescaler #(.BITS(PRE_BITS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .run_i  (run),
    .clr_i  (pre_clr),
    .carry_o(pre_carry)
  );

  wdog_stage_counter #(
    .LONG_STAGE (LONG_STAGE),
    .SHORT_STAGE(SHORT_STAGE)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_core_n),
    .step_i(pre_carry),
    .clr_i (pre_clr),
    .rate_i(rate),
    .ovf_o (ovf)
  );

  always_comb begin
    pulse_d = ovf & ~pre_clr;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) pulse_q <= 1'b0;
    else             pulse_q <= pulse_d;
  end

  assign wdog_rst_o = pulse_q;
endmodule

// File: rtl/wdog_reset_timer_chk.sv
module wdog_reset_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wdog_en_i,
  input logic       lp_green_i,
  input logic       lp_halt_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       wdog_rst_o
);
  // R6
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  // R8
  off_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdog_en_i |=> !wdog_rst_o);

  // R7
  lowpower_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_green_i || lp_halt_i) |=> !wdog_rst_o);

  // R12
  idle_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !wdog_rst_o);

  // R9
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[6]) |=> !wdog_rst_o);

  // R11
  readback_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & 8'hDF) == 8'h00);

  // R11
  readback_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));
endmodule

bind wdog_reset_timer wdog_reset_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wdog_en_i  (wdog_en_i),
  .lp_green_i (lp_green_i),
  .lp_halt_i  (lp_halt_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o),
  .wdog_rst_o (wdog_rst_o)
);

// File: tb/wdog_reset_timer_bench.sv
module wdog_reset_timer_bench;
  localparam int LS = 10;
  localparam int SS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, wdog_en_i, lp_green_i, lp_halt_i, cfg_we_i;
  logic [7:0] cfg_wdata_i;
  logic [7:0] cfg_rdata_o;
  logic       wdog_rst_o;

  int n_cmp = 0;
  int n_bad = 0;
  int m_ticks = 0;
  bit m_rate = 1'b0;
  bit en_lvl = 1'b1;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  wdog_reset_timer #(.LONG_STAGE(LS), .SHORT_STAGE(SS)) u_wdog_reset_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wdog_en_i(wdog_en_i),
    .lp_green_i(lp_green_i), .lp_halt_i(lp_halt_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .wdog_rst_o(wdog_rst_o)
  );

  function automatic int limit_of(input bit r);
    return r ? (1 << SS) : (1 << LS);
  endfunction

  function automatic logic [7:0] readback_of(input bit r);
    return {2'b00, r, 5'b00000};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit tk, input bit gr, input bit hl, input bit we,
                      input logic [7:0] wd, input string tag);
    bit exp;
    @(negedge clk_i);
    tick_i = tk; lp_green_i = gr; lp_halt_i = hl; cfg_we_i = we; cfg_wdata_i = wd;
    wdog_en_i = en_lvl;
    exp = 1'b0;
    if (!en_lvl) m_ticks = 0;
    else if (we && wd[6]) m_ticks = 0;
    else if (tk && !gr && !hl) begin
      m_ticks++;
      if ((m_ticks % 16) == 0 && (m_ticks / 16) >= limit_of(m_rate)) begin
        exp = 1'b1;
        m_ticks = 0;
      end
    end
    if (we) m_rate = wd[5];
    @(posedge clk_i);
    #1;
    check({7'd0, wdog_rst_o}, {7'd0, exp}, tag);
    if (we) check(cfg_rdata_o, readback_of(m_rate), "R11");
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    rst_ni = 1'b0; tick_i = 1'b0; wdog_en_i = 1'b1; lp_green_i = 1'b0;
    lp_halt_i = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check({7'd0, wdog_rst_o}, 8'h00, "R1");
    check(cfg_rdata_o, 8'h00, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    // R12 idle cycles do not count (also covers sync release)
    for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R12");
    // R2 long period
    run_ticks(16 * (1 << LS), "R2");
    // R3 / R6 short period, two consecutive pulses
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h20, "R3");
    run_ticks(2 * 16 * (1 << SS), "R6");
    // R5 writes with strobe clear do not disturb timing
    for (int i = 0; i < 16 * (1 << SS); i++)
      step(1'b1, 1'b0, 1'b0, (i % 97) == 5, 8'h2E, "R5");
    // R4 restart mid-period
    run_ticks(3000, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h60, "R4");
    run_ticks(16 * (1 << SS) + 10, "R4");
    // R9 clear on the overflow cycle
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h60, "R9");
    run_ticks(16 * (1 << SS) - 1, "R9");
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h60, "R9");
    run_ticks(16 * (1 << SS), "R9");
    // R10 shrink rate while count above short limit
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h40, "R10");
    run_ticks(16 * 300 + 5, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h20, "R10");
    run_ticks(16, "R10");
    // R7 random ticks with low-power intervals and rare writes
    for (int i = 0; i < 30000; i++) begin
      bit w;
      logic [7:0] d;
      w = (($urandom % 300) == 0);
      d = 8'($urandom) & 8'h7F;
      step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0, w, d, "R7");
    end
    // R7 long low-power stretch with ticks: count frozen
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h60, "R7");
    run_ticks(16 * (1 << SS) - 3, "R7");
    for (int i = 0; i < 5000; i++) step(1'b1, i[0], ~i[0], 1'b0, 8'h00, "R7");
    run_ticks(3, "R7");
    // R8 disabled: no pulses, count held at zero
    run_ticks(100, "R8");
    en_lvl = 1'b0;
    run_ticks(16 * (1 << SS) * 3, "R8");
    en_lvl = 1'b1;
    run_ticks(16 * (1 << SS), "R8");
    // R12 random tick gating only
    for (int i = 0; i < 12000; i++)
      step(($urandom % 3) == 0, 1'b0, 1'b0, 1'b0, 8'h00, "R12");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule